// File: doc/BRIEF.md
# Half-Duplex SPI Transaction Engine

This block is an SPI master that runs one framed transaction per command. Software first fills a small byte buffer through a word-addressed register port, sets up a configuration word (serial clock divider, clock edge behaviour, bit order, chip-select polarity and a mask of usable chip selects), and then writes a command word. The command names one of four chip selects and gives two byte counts: a total count and a transmit count. The engine sends the transmit bytes from the buffer first. It then clocks in the remaining bytes and writes them into the same buffer, starting at its first entry.

A flag in the command keeps the chosen chip select asserted once the transaction ends. Software can therefore chain several commands into one longer device access, for example an opcode and address segment followed by a read segment. A busy output, which is also visible in a status word, stays high from the accepted command until the last half-bit of the frame has elapsed.

Top module: `spi_txn_engine`

## Requirements
- R1: After reset the configuration, status and every buffer entry read as zero, busy is low, SCK and MOSI are low, and every chip-select pin is high (inactive).
- R2: Word addresses are: 0 configuration, 1 command (write only, reads as zero), 2 status, 8 to 16 buffer entries 0 to 8 (data in bits 7:0). Configuration bits are: 0 enable, 1 clock-level select, 4 LSB-first, 7 active-high chip select, 11 late sampling, 15:12 chip-select mask, 28:16 divider. Command bits are: 4:0 total count, 12:8 transmit count, 16 hold chip select, 21:20 chip-select index. Status bits are: 0 busy, 12:8 received byte count. A configuration write reads back unchanged in all defined bits.
- R3: Each half-bit lasts `div` reference clocks, with a divider of 0 acting as 1. A frame of T bytes holds busy high for exactly div*(16*T+2) clocks: one lead half-bit, 16 half-bits per byte, and one trailing half-bit.
- R4: The first X bytes of a frame are sent from buffer entries 0 to X-1 in index order, each MSB first, or LSB first when bit 4 is set. MOSI is low during the receive bytes and while idle.
- R5: The last T-X bytes of a frame are sampled from MISO into buffer entries 0 to T-X-1, using the same bit order. The status received count then reads T-X.
- R6: SCK idles at bit 1 XOR bit 11. With bit 11 clear, data is valid before the first SCK edge of each bit and is sampled on that edge. With bit 11 set, data changes on the first edge and is sampled on the second.
- R7: Only the chip select named by the index is ever asserted, and only if its mask bit is set. A pin is low when asserted unless bit 7 is set, in which case it is high when asserted.
- R8: With the hold flag clear, the chip select deasserts when the frame ends. With the flag set, it stays asserted after busy falls, until a later command ends with the flag clear.
- R9: A command with a total count of zero starts nothing: busy stays low.
- R10: A total count above 9 acts as 9, and a transmit count above the effective total acts as that total.
- R11: While enable (bit 0) is clear, commands are ignored.
- R12: While busy, writes to the configuration, the command or the buffer have no effect.
- R13: Busy rises only on the cycle after an accepted command write, and status bit 0 mirrors it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| busy | output | 1 | Transaction in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select pins, polarity set by configuration |

## Verification
The frame engine is run with transmit-only, receive-only and mixed write-then-read frames, in both sampling modes, in both bit orders and at three divider values. Each combination separates a different kind of error: byte-order and bit-order mistakes, an off-by-one at the transmit/receive boundary, and the wrong edge for sampling or shifting. A bench slave replies with a distinct byte at every position, so any shift between phases shows up as a wrong buffer value. Further frames cover chip-select chaining with the hold flag, masking and polarity, count clamping, a zero total, a cleared enable, and writes issued in the middle of a frame. These separate control-path faults from faults in the serial datapath.

// File: rtl/spi_txn_pkg.sv
`timescale 1ns/1ps
package spi_txn_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned DIV_W    = 13;
    localparam int unsigned CNT_W    = 5;
    localparam int unsigned NUM_CS   = 4;
    localparam int unsigned CS_W     = $clog2(NUM_CS);

    localparam int unsigned ADDR_CFG  = 0;
    localparam int unsigned ADDR_CMD  = 1;
    localparam int unsigned ADDR_STAT = 2;
    localparam int unsigned ADDR_BUF  = 8;

    typedef struct packed {
        logic              en;
        logic              clk_xor;
        logic              lsb_first;
        logic              cs_high;
        logic              late;
        logic [NUM_CS-1:0] cs_mask;
        logic [DIV_W-1:0]  div;
    } spi_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] txn;
        logic             hold;
        logic [CS_W-1:0]  sel;
    } spi_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } spi_state_e;

    function automatic spi_cfg_t unpack_cfg(input logic [DATA_W-1:0] w);
        spi_cfg_t c;
        c.en        = w[0];
        c.clk_xor   = w[1];
        c.lsb_first = w[4];
        c.cs_high   = w[7];
        c.late      = w[11];
        c.cs_mask   = w[15:12];
        c.div       = w[28:16];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg(input spi_cfg_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = c.en;
        w[1]     = c.clk_xor;
        w[4]     = c.lsb_first;
        w[7]     = c.cs_high;
        w[11]    = c.late;
        w[15:12] = c.cs_mask;
        w[28:16] = c.div;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] min_cnt(input logic [CNT_W-1:0] a,
                                                  input logic [CNT_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic spi_cmd_t unpack_cmd(input logic [DATA_W-1:0] w,
                                            input logic [CNT_W-1:0] cap);
        spi_cmd_t c;
        c.total = min_cnt(w[4:0], cap);
        c.txn   = min_cnt(w[12:8], c.total);
        c.hold  = w[16];
        c.sel   = w[21:20];
        return c;
    endfunction

endpackage

// File: rtl/spi_txn_regs.sv
`timescale 1ns/1ps
module spi_txn_regs
    import spi_txn_pkg::*;
#(
    parameter int unsigned NBYTES = 9,
    parameter int unsigned IDX_W  = $clog2(NBYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     busy,
    input  logic                     rx_we,
    input  logic [IDX_W-1:0]         rx_idx,
    input  logic [7:0]               rx_byte,
    input  logic [CNT_W-1:0]         rx_count,
    output spi_cfg_t                 cfg,
    output logic                     start,
    output spi_cmd_t                 cmd,
    output logic [NBYTES-1:0][7:0]   buf_q
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(NBYTES);

    spi_cfg_t cfg_q;
    logic     sw_wr;

    assign sw_wr = wr_en && !busy;
    assign cfg   = cfg_q;
    assign cmd   = unpack_cmd(wr_data, CAP);
    assign start = sw_wr && (wr_addr == ADDR_W'(ADDR_CMD)) && cfg_q.en
                   && (cmd.total != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (sw_wr && wr_addr == ADDR_W'(ADDR_CFG)) begin
            cfg_q <= unpack_cfg(wr_data);
        end
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                buf_q[i] <= '0;
            end else if (rx_we && rx_idx == IDX_W'(i)) begin
                buf_q[i] <= rx_byte;
            end else if (sw_wr && wr_addr == ADDR_W'(ADDR_BUF + i)) begin
                buf_q[i] <= wr_data[7:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_CFG)) begin
            rd_data = pack_cfg(cfg_q);
        end else if (rd_addr == ADDR_W'(ADDR_STAT)) begin
            rd_data[0]    = busy;
            rd_data[12:8] = rx_count;
        end else begin
            for (int i = 0; i < NBYTES; i++) begin
                if (rd_addr == ADDR_W'(ADDR_BUF + i)) begin
                    rd_data[7:0] = buf_q[i];
                end
            end
        end
    end

endmodule

// File: rtl/spi_txn_halftick.sv
`timescale 1ns/1ps
module spi_txn_halftick
    import spi_txn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;

    assign last = (div == '0) ? '0 : div - DIV_W'(1);
    assign tick = run && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/spi_txn_seq.sv
`timescale 1ns/1ps
module spi_txn_seq
    import spi_txn_pkg::*;
#(
    parameter int unsigned NBYTES = 9,
    parameter int unsigned IDX_W  = $clog2(NBYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  spi_cmd_t                 cmd,
    input  spi_cfg_t                 cfg,
    input  logic [NBYTES-1:0][7:0]   buf_q,
    input  logic                     tick,
    input  logic                     miso,
    output logic                     run,
    output logic                     sck,
    output logic                     mosi,
    output logic                     rx_we,
    output logic [IDX_W-1:0]         rx_idx,
    output logic [7:0]               rx_byte,
    output logic [CNT_W-1:0]         rx_count,
    output logic                     cs_on,
    output logic [CS_W-1:0]          cs_sel
);

    spi_state_e       st_q;
    logic             half_q;
    logic [2:0]       bit_q;
    logic [IDX_W-1:0] byte_q;
    logic [IDX_W-1:0] tot_q;
    logic [IDX_W-1:0] txn_q;
    logic             hold_q;
    logic [7:0]       rx_sh_q;
    logic [CNT_W-1:0] rxn_q;

    logic             rx_phase;
    logic             byte_end;
    logic [7:0]       tx_byte;
    logic             tx_bit;
    logic [7:0]       rx_next;

    assign run      = (st_q != ST_IDLE);
    assign rx_phase = (byte_q >= txn_q);
    assign byte_end = (st_q == ST_SHIFT) && tick && half_q && (bit_q == 3'd7);
    assign rx_we    = byte_end && rx_phase;
    assign rx_idx   = byte_q - txn_q;
    assign rx_byte  = rx_sh_q;
    assign rx_count = rxn_q;

    always_comb begin
        tx_byte = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (byte_q == IDX_W'(i)) begin
                tx_byte = buf_q[i];
            end
        end
        tx_bit  = cfg.lsb_first ? tx_byte[bit_q] : tx_byte[3'd7 - bit_q];
        rx_next = cfg.lsb_first ? {miso, rx_sh_q[7:1]} : {rx_sh_q[6:0], miso};
    end

    assign mosi = ((st_q == ST_LEAD) || (st_q == ST_SHIFT)) && !rx_phase && tx_bit;
    assign sck  = (cfg.clk_xor ^ cfg.late)
                  ^ ((st_q == ST_SHIFT) && (cfg.late ? !half_q : half_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            half_q  <= 1'b0;
            bit_q   <= '0;
            byte_q  <= '0;
            tot_q   <= '0;
            txn_q   <= '0;
            hold_q  <= 1'b0;
            rx_sh_q <= '0;
            rxn_q   <= '0;
            cs_on   <= 1'b0;
            cs_sel  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_LEAD;
                        half_q <= 1'b0;
                        bit_q  <= '0;
                        byte_q <= '0;
                        tot_q  <= IDX_W'(cmd.total);
                        txn_q  <= IDX_W'(cmd.txn);
                        hold_q <= cmd.hold;
                        rxn_q  <= '0;
                        cs_on  <= 1'b1;
                        cs_sel <= cmd.sel;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        st_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!half_q) begin
                            rx_sh_q <= rx_next;
                            half_q  <= 1'b1;
                        end else begin
                            half_q <= 1'b0;
                            if (bit_q == 3'd7) begin
                                bit_q  <= '0;
                                byte_q <= byte_q + IDX_W'(1);
                                if (rx_phase) begin
                                    rxn_q <= rxn_q + CNT_W'(1);
                                end
                                if (byte_q == tot_q - IDX_W'(1)) begin
                                    st_q <= ST_TAIL;
                                end
                            end else begin
                                bit_q <= bit_q + 3'd1;
                            end
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        st_q <= ST_IDLE;
                        if (!hold_q) begin
                            cs_on <= 1'b0;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_txn_csdrv.sv
`timescale 1ns/1ps
module spi_txn_csdrv
    import spi_txn_pkg::*;
(
    input  logic              cs_on,
    input  logic [CS_W-1:0]   cs_sel,
    input  logic [NUM_CS-1:0] cs_mask,
    input  logic              cs_high,
    output logic [NUM_CS-1:0] spi_cs
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_pin
        logic act;
        assign act       = cs_on && (cs_sel == CS_W'(i)) && cs_mask[i];
        assign spi_cs[i] = cs_high ? act : !act;
    end

endmodule

// File: rtl/spi_txn_engine.sv
`timescale 1ns/1ps
module spi_txn_engine
    import spi_txn_pkg::*;
#(
    parameter int unsigned NBYTES = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [4:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [3:0]        spi_cs
);

    localparam int unsigned IDX_W = $clog2(NBYTES + 1);

    spi_cfg_t               cfg_w;
    spi_cmd_t               cmd_w;
    logic                   start_w;
    logic [NBYTES-1:0][7:0] buf_w;
    logic                   tick_w;
    logic                   rx_we_w;
    logic [IDX_W-1:0]       rx_idx_w;
    logic [7:0]             rx_byte_w;
    logic [CNT_W-1:0]       rx_count_w;
    logic                   cs_on_w;
    logic [CS_W-1:0]        cs_sel_w;

    spi_txn_regs #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .busy     (busy),
        .rx_we    (rx_we_w),
        .rx_idx   (rx_idx_w),
        .rx_byte  (rx_byte_w),
        .rx_count (rx_count_w),
        .cfg      (cfg_w),
        .start    (start_w),
        .cmd      (cmd_w),
        .buf_q    (buf_w)
    );

    spi_txn_halftick u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (cfg_w.div),
        .tick (tick_w)
    );

    spi_txn_seq #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_w),
        .cmd      (cmd_w),
        .cfg      (cfg_w),
        .buf_q    (buf_w),
        .tick     (tick_w),
        .miso     (miso),
        .run      (busy),
        .sck      (sck),
        .mosi     (mosi),
        .rx_we    (rx_we_w),
        .rx_idx   (rx_idx_w),
        .rx_byte  (rx_byte_w),
        .rx_count (rx_count_w),
        .cs_on    (cs_on_w),
        .cs_sel   (cs_sel_w)
    );

    spi_txn_csdrv u_cs (
        .cs_on   (cs_on_w),
        .cs_sel  (cs_sel_w),
        .cs_mask (cfg_w.cs_mask),
        .cs_high (cfg_w.cs_high),
        .spi_cs  (spi_cs)
    );

endmodule

// File: rtl/spi_txn_chk.sv
`timescale 1ns/1ps
module spi_txn_chk
    import spi_txn_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [4:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic              busy,
    input logic              sck,
    input logic              mosi,
    input logic [3:0]        spi_cs,
    input spi_cfg_t          cfg
);

    logic cmd_wr;
    assign cmd_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CMD));

    // R7: at most one chip select asserted
    a_r7_single_cs: assert property (@(posedge clk) disable iff (rst)
        $countones(cfg.cs_high ? spi_cs : ~spi_cs) <= 1);

    // R6: clock rests at its idle level between frames
    a_r6_sck_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == (cfg.clk_xor ^ cfg.late)));

    // R4: data line quiet while idle
    a_r4_mosi_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mosi);

    // R9: zero-length command starts nothing
    a_r9_zero_no_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && wr_data[4:0] == 5'd0) |=> !busy);

    // R11: disabled engine ignores commands
    a_r11_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && !cfg.en) |=> !busy);

    // R12: configuration frozen during a frame
    a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg));

    // R13: busy only rises after a command write
    a_r13_busy_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_wr));

endmodule

bind spi_txn_engine spi_txn_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (busy),
    .sck     (sck),
    .mosi    (mosi),
    .spi_cs  (spi_cs),
    .cfg     (cfg_w)
);

// File: tb/test_spi_txn_engine.sv
`timescale 1ns/1ps
module test_spi_txn_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy;
    logic        sck;
    logic        mosi;
    logic        miso = 1'b0;
    logic [3:0]  spi_cs;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench-side view of the current configuration
    bit b_late, b_idle, b_lsb;
    int b_div;
    logic [31:0] cur_cfg;
    logic [7:0] exp_buf [0:8];

    // slave model state
    int sl_seed;
    int ob, ib;
    logic mo_bits [0:127];
    logic mosi_prev = 1'b0;

    always #2.5 clk = ~clk;

    spi_txn_engine i_spi_txn_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .sck(sck), .mosi(mosi),
        .miso(miso), .spi_cs(spi_cs)
    );

    function automatic logic [7:0] sl_byte(input int j);
        return 8'(sl_seed * 31 + j * 53 + 7);
    endfunction

    function automatic logic sbit(input int k);
        logic [7:0] b;
        b = sl_byte(k / 8);
        return b_lsb ? b[k % 8] : b[7 - (k % 8)];
    endfunction

    always @(negedge clk) mosi_prev = mosi;

    always @(sck) begin
        if (busy === 1'b1) begin
            if ((sck != b_idle) != b_late) begin
                if (ib < 128) mo_bits[ib] = mosi_prev;
                ib = ib + 1;
            end else begin
                miso = sbit(ob);
                ob = ob + 1;
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        rd_addr = 5'(addr);
        #1 data = rd_data;
    endtask

    function automatic logic [31:0] mk_cfg(input bit en, input bit cx, input bit lsb,
                                           input bit csh, input bit late,
                                           input logic [3:0] mask, input int div);
        logic [31:0] w;
        w = '0;
        w[0] = en; w[1] = cx; w[4] = lsb; w[7] = csh; w[11] = late;
        w[15:12] = mask; w[28:16] = 13'(div);
        return w;
    endfunction

    function automatic logic [31:0] mk_cmd(input int tot, input int tx, input bit hold,
                                           input int sel);
        logic [31:0] w;
        w = '0;
        w[4:0] = 5'(tot); w[12:8] = 5'(tx); w[16] = hold; w[21:20] = 2'(sel);
        return w;
    endfunction

    task automatic set_cfg(input logic [31:0] w);
        reg_write(0, w);
        cur_cfg = w;
        b_late = w[11];
        b_idle = w[1] ^ w[11];
        b_lsb  = w[4];
        b_div  = (w[28:16] == 0) ? 1 : int'(w[28:16]);
    endtask

    task automatic load_buf(input int seed, input int n);
        for (int i = 0; i < n; i++) begin
            exp_buf[i] = 8'(seed + i * 13 + 1);
            reg_write(8 + i, {24'b0, exp_buf[i]});
        end
    endtask

    // Runs one frame and checks timing, MOSI stream, received bytes and status.
    task automatic do_txn(input int tot_req, input int tx_req, input bit hold,
                          input int sel, input int seed, input bit poke,
                          output logic [3:0] cs_mid);
        int tot, tx, cnt;
        logic [31:0] rd;
        logic [7:0] got;
        tot = (tot_req > 9) ? 9 : tot_req;
        tx  = (tx_req > tot) ? tot : tx_req;
        sl_seed = seed; ib = 0; ob = 0;
        if (!b_late) begin miso = sbit(0); ob = 1; end
        reg_write(1, mk_cmd(tot_req, tx_req, hold, sel));
        cs_mid = spi_cs;
        cnt = 0;
        while (busy === 1'b1 && cnt < 100000) begin
            cnt++;
            if (poke) begin
                if (cnt == 4) begin wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'h0; end
                if (cnt == 5) begin wr_addr = 5'd13; wr_data = 32'h5A; end
                if (cnt == 6) begin wr_addr = 5'd1; wr_data = mk_cmd(3, 0, 0, 0); end
                if (cnt == 7) wr_en = 1'b0;
            end
            @(negedge clk);
        end
        chk("R3 busy length", cnt, b_div * (16 * tot + 2));
        chk("R6 sampling edges", ib, tot * 8);
        for (int j = 0; j < tot; j++) begin
            got = '0;
            for (int b = 0; b < 8; b++) begin
                if (b_lsb) got[b] = mo_bits[j*8+b]; else got[7-b] = mo_bits[j*8+b];
            end
            chk("R4 mosi byte", got, (j < tx) ? exp_buf[j] : 8'h00);
        end
        for (int i = 0; i < tot - tx; i++) begin
            reg_read(8 + i, rd);
            chk("R5 rx byte", rd, {24'b0, sl_byte(tx + i)});
            exp_buf[i] = sl_byte(tx + i);
        end
        reg_read(2, rd);
        chk("R5 R13 status", rd, {19'b0, 5'(tot - tx), 8'b0});
    endtask

    task automatic t_reset();
        logic [31:0] rd;
        chk("R1 busy", busy, 0);
        chk("R1 sck", sck, 0);
        chk("R1 mosi", mosi, 0);
        chk("R1 cs", spi_cs, 4'hF);
        reg_read(0, rd); chk("R1 cfg", rd, 0);
        reg_read(2, rd); chk("R1 status", rd, 0);
        reg_read(16, rd); chk("R1 buf", rd, 0);
    endtask

    task automatic t_mode0_msb();
        logic [31:0] rd;
        logic [3:0] cs;
        set_cfg(mk_cfg(1, 0, 0, 0, 0, 4'hF, 2));
        reg_read(0, rd); chk("R2 cfg readback", rd, cur_cfg);
        chk("R6 idle low", sck, 0);
        load_buf(3, 3);
        do_txn(6, 3, 0, 1, 11, 0, cs);
        chk("R7 cs during", cs, 4'b1101);
        chk("R8 cs after", spi_cs, 4'hF);
    endtask

    task automatic t_late_lsb();
        logic [3:0] cs;
        set_cfg(mk_cfg(1, 0, 1, 0, 1, 4'hF, 1));
        chk("R6 idle high", sck, 1);
        load_buf(40, 1);
        do_txn(4, 1, 0, 0, 5, 0, cs);
        chk("R7 cs during", cs, 4'b1110);
    endtask

    task automatic t_chain();
        logic [3:0] cs;
        set_cfg(mk_cfg(1, 1, 0, 0, 1, 4'hF, 3));
        chk("R6 idle low xor", sck, 0);
        load_buf(90, 2);
        do_txn(2, 2, 1, 2, 7, 0, cs);
        chk("R8 held after", spi_cs, 4'b1011);
        do_txn(3, 0, 0, 2, 8, 0, cs);
        chk("R8 held during", cs, 4'b1011);
        chk("R8 released", spi_cs, 4'hF);
    endtask

    task automatic t_zero();
        logic [31:0] rd;
        reg_write(1, mk_cmd(0, 0, 0, 0));
        chk("R9 busy", busy, 0);
        reg_read(8, rd); chk("R9 buf kept", rd, {24'b0, exp_buf[0]});
    endtask

    task automatic t_clamp();
        logic [3:0] cs;
        set_cfg(mk_cfg(1, 0, 0, 0, 0, 4'hF, 1));
        load_buf(17, 9);
        do_txn(20, 12, 0, 3, 2, 0, cs);
        chk("R10 cs", cs, 4'b0111);
        do_txn(9, 0, 0, 0, 3, 0, cs);
    endtask

    task automatic t_disabled();
        set_cfg(mk_cfg(0, 0, 0, 0, 0, 4'hF, 1));
        reg_write(1, mk_cmd(2, 1, 0, 0));
        chk("R11 no busy", busy, 0);
        chk("R11 cs idle", spi_cs, 4'hF);
    endtask

    task automatic t_polarity();
        logic [3:0] cs;
        set_cfg(mk_cfg(1, 0, 0, 1, 0, 4'b1011, 1));
        chk("R7 pins idle", spi_cs, 4'h0);
        load_buf(60, 1);
        do_txn(1, 1, 0, 2, 9, 0, cs);
        chk("R7 masked", cs, 4'h0);
        do_txn(2, 1, 0, 3, 4, 0, cs);
        chk("R7 high active", cs, 4'b1000);
    endtask

    task automatic t_busy_writes();
        logic [31:0] rd;
        logic [3:0] cs;
        set_cfg(mk_cfg(1, 0, 0, 0, 0, 4'hF, 3));
        load_buf(70, 6);
        do_txn(2, 2, 0, 0, 6, 1, cs);
        reg_read(0, rd); chk("R12 cfg kept", rd, cur_cfg);
        reg_read(13, rd); chk("R12 buf kept", rd, {24'b0, exp_buf[5]});
        @(negedge clk);
        chk("R12 no restart", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode0_msb();
        t_late_lsb();
        t_chain();
        t_zero();
        t_clamp();
        t_disabled();
        t_polarity();
        t_busy_writes();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            errs++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule